// File: doc/BRIEF.md
# Banded SPI Display Serializer

This block takes 16-bit RGBA4444 pixels from a ready/valid stream and shifts them out to a display over a write-only SPI link. It drives the serial clock, the serial data line, an active-low chip select and a data/command line. The screen is not held in one piece. It is rendered in horizontal bands of `BAND_ROWS` rows, and only one band sits in the local colour buffer at a time. The serializer therefore counts columns and rows itself. It frames each band with its own chip-select window and reports when a band and when a whole frame have been sent. When `V_RES` is not a multiple of `BAND_ROWS`, the last band is shorter.

A bypass select gives the four display lines to an external host controller, which uses them to configure the display. While bypass is high, the serializer freezes where it is and refuses new pixels. When bypass is released, it carries on with the same bit. The serial clock equals the system clock divided by `2*SCK_DIV`, so a 48 MHz system clock with `SCK_DIV=1` gives the highest allowed rate of 24 MHz.

The control is a four-state machine:
- **ST_IDLE**: chip select is high and a pixel is awaited. It moves to ST_SHIFT when a pixel is accepted.
- **ST_SHIFT**: sixteen clock periods are sent. On the last falling edge it moves to ST_WAIT if the band has more pixels, or to ST_CLOSE if the band is complete.
- **ST_WAIT**: chip select is held low and the next pixel of the band is awaited. It moves to ST_SHIFT when a pixel is accepted.
- **ST_CLOSE**: chip select goes high and the done pulses are raised for one cycle. It always moves to ST_IDLE.

Top module: `banded_spi_tx`

## Requirements
- R1: After reset `lcd_cs_n`=1, `lcd_sck`=0, `lcd_dc`=1, `s_ready`=1, and `band_done` and `frame_done` are 0.
- R2: Each accepted pixel is sent as 16 bits, bit 15 first, on 16 rising edges of `lcd_sck`. `lcd_mosi` never changes while `lcd_sck` is high.
- R3: `lcd_cs_n` goes low when the first pixel of a band is accepted and stays low until the last bit of that band has been sent. It rises only together with `band_done`. `lcd_dc` is 1 whenever the serializer owns the pins.
- R4: `lcd_sck` idles low. Inside a pixel, each clock is high for `SCK_DIV` system cycles and has a period of `2*SCK_DIV` cycles.
- R5: A band holds `H_RES*BAND_ROWS` pixels. The last band of a frame holds `H_RES*(V_RES mod BAND_ROWS)` pixels when that remainder is not zero.
- R6: `band_done` is a one-cycle pulse after the last bit of every band. `frame_done` pulses in the same cycle as the `band_done` of the final band. Counting then restarts for the next frame.
- R7: `s_ready` is 0 from the acceptance of a pixel until its last falling clock edge, so it is never 1 while `lcd_sck` is high.
- R8: While `bypass_en`=1, `lcd_sck`, `lcd_mosi`, `lcd_cs_n` and `lcd_dc` equal `host_sck`, `host_mosi`, `host_cs_n` and `host_dc`.
- R9: While `bypass_en`=1, `s_ready` is 0 and the serializer state is frozen. An idle serializer stays idle. An interrupted pixel resumes after release and is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Pixel stream valid |
| s_data | input | 16 | Pixel, RGBA4444 |
| s_ready | output | 1 | Pixel stream ready |
| bypass_en | input | 1 | Hand display pins to the host |
| host_sck | input | 1 | Host serial clock |
| host_mosi | input | 1 | Host serial data |
| host_cs_n | input | 1 | Host chip select |
| host_dc | input | 1 | Host data/command |
| lcd_sck | output | 1 | Display serial clock |
| lcd_mosi | output | 1 | Display serial data |
| lcd_cs_n | output | 1 | Display chip select, active low |
| lcd_dc | output | 1 | Display data/command, 1 = pixel data |
| band_done | output | 1 | One-cycle pulse at the end of a band |
| frame_done | output | 1 | One-cycle pulse at the end of the last band |

## Verification
The bench uses a 3x5 screen with 2-row bands, so the last band is a short one of 3 pixels. A design that counted only whole bands would end that band at the wrong pixel, or would run the band into the next frame. The bench also sends pixels with idle gaps, and a design that dropped chip select between pixels of one band would show a `lcd_cs_n` rise with no matching `band_done`. Bypass is taken once while idle and once in the middle of a pixel. A design that kept shifting, or that accepted a pixel during bypass, would deliver a corrupted word or would start a band with no data behind it.

// File: rtl/bspi_pkg.sv
package bspi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CLOSE = 2'd3
    } tx_state_e;
endpackage

// File: rtl/bspi_sck_gen.sv
module bspi_sck_gen #(
    parameter int SCK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic sck,
    output logic fall_tick
);
    localparam int CW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCK_DIV - 1);

    logic [CW-1:0] cnt;
    logic          half_end;

    assign half_end  = run && (cnt == LAST);
    assign fall_tick = half_end && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (restart) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (half_end) begin
            cnt <= '0;
            sck <= ~sck;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bspi_shifter.sv
module bspi_shifter #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] din,
    input  logic          shift,
    output logic          msb,
    output logic          last_bit
);
    localparam int BW = $clog2(PW);

    logic [PW-1:0] shreg;
    logic [BW-1:0] bcnt;

    assign msb      = shreg[PW-1];
    assign last_bit = (bcnt == BW'(PW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (load) begin
            shreg <= din;
            bcnt  <= '0;
        end else if (shift && !last_bit) begin
            shreg <= {shreg[PW-2:0], 1'b0};
            bcnt  <= bcnt + 1'b1;
        end
    end
endmodule

// File: rtl/bspi_band_count.sv
module bspi_band_count #(
    parameter int H_RES     = 240,
    parameter int V_RES     = 320,
    parameter int BAND_ROWS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic px_done,
    output logic band_last,
    output logic frame_last
);
    localparam int CW = $clog2((H_RES > 1) ? H_RES : 2);
    localparam int RW = $clog2((V_RES > 1) ? V_RES : 2);
    localparam int BW = $clog2((BAND_ROWS > 1) ? BAND_ROWS : 2);

    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic [BW-1:0] rib;
    logic          row_end;

    assign row_end    = (col == CW'(H_RES - 1));
    assign frame_last = row_end && (row == RW'(V_RES - 1));
    assign band_last  = row_end && ((rib == BW'(BAND_ROWS - 1)) || (row == RW'(V_RES - 1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
            rib <= '0;
        end else if (px_done) begin
            if (row_end) begin
                col <= '0;
                row <= frame_last ? '0 : row + 1'b1;
                rib <= band_last  ? '0 : rib + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/banded_spi_tx.sv
module banded_spi_tx
    import bspi_pkg::*;
#(
    parameter int H_RES     = 240,
    parameter int V_RES     = 320,
    parameter int BAND_ROWS = 64,
    parameter int SCK_DIV   = 1,
    parameter int PIX_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic [PIX_W-1:0] s_data,
    output logic             s_ready,
    input  logic             bypass_en,
    input  logic             host_sck,
    input  logic             host_mosi,
    input  logic             host_cs_n,
    input  logic             host_dc,
    output logic             lcd_sck,
    output logic             lcd_mosi,
    output logic             lcd_cs_n,
    output logic             lcd_dc,
    output logic             band_done,
    output logic             frame_done
);
    tx_state_e state, state_nx;

    logic accept, run, fall_tick, last_bit, px_fin;
    logic band_last, frame_last, frame_end_r;
    logic eng_sck, eng_mosi, eng_cs_n;

    // stream side
    assign s_ready = !bypass_en && ((state == ST_IDLE) || (state == ST_WAIT));
    assign accept  = s_valid && s_ready;
    assign run     = (state == ST_SHIFT) && !bypass_en;
    assign px_fin  = fall_tick && last_bit;

    bspi_sck_gen #(.SCK_DIV(SCK_DIV)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept),
        .run       (run),
        .sck       (eng_sck),
        .fall_tick (fall_tick)
    );

    bspi_shifter #(.PW(PIX_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .din      (s_data),
        .shift    (fall_tick),
        .msb      (eng_mosi),
        .last_bit (last_bit)
    );

    bspi_band_count #(.H_RES(H_RES), .V_RES(V_RES), .BAND_ROWS(BAND_ROWS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .px_done    (px_fin),
        .band_last  (band_last),
        .frame_last (frame_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            frame_end_r <= 1'b0;
        end else begin
            state <= state_nx;
            if (px_fin)
                frame_end_r <= frame_last;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_SHIFT;
            ST_SHIFT: if (px_fin) state_nx = band_last ? ST_CLOSE : ST_WAIT;
            ST_WAIT:  if (accept) state_nx = ST_SHIFT;
            ST_CLOSE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_cs_n   = 1'b1;
        band_done  = 1'b0;
        frame_done = 1'b0;
        unique case (state)
            ST_IDLE:  eng_cs_n = 1'b1;
            ST_SHIFT: eng_cs_n = 1'b0;
            ST_WAIT:  eng_cs_n = 1'b0;
            ST_CLOSE: begin
                eng_cs_n   = 1'b1;
                band_done  = 1'b1;
                frame_done = frame_end_r;
            end
            default:  eng_cs_n = 1'b1;
        endcase
    end

    // pin multiplexer
    assign lcd_sck  = bypass_en ? host_sck  : eng_sck;
    assign lcd_mosi = bypass_en ? host_mosi : eng_mosi;
    assign lcd_cs_n = bypass_en ? host_cs_n : eng_cs_n;
    assign lcd_dc   = bypass_en ? host_dc   : 1'b1;
endmodule

// File: rtl/banded_spi_tx_chk.sv
module banded_spi_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic s_ready,
    input logic bypass_en,
    input logic lcd_sck,
    input logic lcd_mosi,
    input logic lcd_cs_n,
    input logic band_done,
    input logic frame_done
);
    a_r7_ready_low_in_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_en && lcd_sck) |-> !s_ready);

    a_r9_bypass_blocks_stream: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_en |-> !s_ready);

    a_r2_mosi_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_en && $past(!bypass_en) && lcd_sck && $past(lcd_sck)) |-> $stable(lcd_mosi));

    a_r3_cs_rise_only_at_band_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_en && $past(!bypass_en) && $rose(lcd_cs_n)) |-> band_done);

    a_r6_frame_with_band: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> band_done);

    a_r6_band_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        band_done |=> !band_done);
endmodule

bind banded_spi_tx banded_spi_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ready    (s_ready),
    .bypass_en  (bypass_en),
    .lcd_sck    (lcd_sck),
    .lcd_mosi   (lcd_mosi),
    .lcd_cs_n   (lcd_cs_n),
    .band_done  (band_done),
    .frame_done (frame_done)
);

// File: tb/banded_spi_tx_test.sv
module banded_spi_tx_test;
    localparam int H = 3, V = 5, BR = 2, DIV = 2, PX = H * V;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic s_valid = 1'b0;
    logic [15:0] s_data = '0;
    logic s_ready;
    logic bypass_en = 1'b0;
    logic host_sck = 1'b0, host_mosi = 1'b0, host_cs_n = 1'b1, host_dc = 1'b0;
    logic lcd_sck, lcd_mosi, lcd_cs_n, lcd_dc, band_done, frame_done;

    banded_spi_tx #(.H_RES(H), .V_RES(V), .BAND_ROWS(BR), .SCK_DIV(DIV), .PIX_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .bypass_en(bypass_en), .host_sck(host_sck), .host_mosi(host_mosi),
        .host_cs_n(host_cs_n), .host_dc(host_dc), .lcd_sck(lcd_sck), .lcd_mosi(lcd_mosi),
        .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .band_done(band_done), .frame_done(frame_done)
    );

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // display model: sample on rising edge
    logic [15:0] rx_sh = '0;
    int rx_bits = 0, rx_n = 0;
    logic [15:0] rx_mem [0:127];
    always @(posedge lcd_sck) begin
        if (!bypass_en && !lcd_cs_n) begin
            rx_sh = {rx_sh[14:0], lcd_mosi};
            rx_bits++;
            if (rx_bits == 16) begin
                rx_mem[rx_n[6:0]] = rx_sh;
                rx_n++;
                rx_bits = 0;
            end
        end
    end

    // pin monitor
    int hi_len = 0, since_rise = 0, sck_err = 0, rdy_err = 0, dc_err = 0;
    int bd_n = 0, fd_n = 0, csr_n = 0;
    int bd_pos [0:31];
    int fd_pos [0:31];
    int csr_pos [0:31];
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (rst_n && !bypass_en) begin
            since_rise++;
            if (lcd_sck) hi_len++;
            if (prev_sck && !lcd_sck) begin
                if (hi_len != DIV) sck_err++;
                hi_len = 0;
            end
            if (lcd_sck && !prev_sck) begin
                if (rx_bits != 1 && since_rise != 2 * DIV) sck_err++;
                since_rise = 0;
            end
            if (lcd_sck && s_ready) rdy_err++;
            if (!lcd_cs_n && !lcd_dc) dc_err++;
            if (band_done) begin bd_pos[bd_n[4:0]] = rx_n; bd_n++; end
            if (frame_done) begin fd_pos[fd_n[4:0]] = rx_n; fd_n++; end
            if (lcd_cs_n && !prev_cs) begin csr_pos[csr_n[4:0]] = rx_n; csr_n++; end
            prev_sck = lcd_sck;
            prev_cs  = lcd_cs_n;
        end
    end

    function automatic logic [15:0] px_val(input int kind, input int i);
        case (kind)
            1:       return 16'h1234 + 16'(i) * 16'h1111;
            2:       return (16'h8000 >> i) | (16'h0001 << i);
            default: return 16'hF0F0 ^ (16'(i) * 16'h0707);
        endcase
    endfunction

    task automatic send_px(input logic [15:0] d);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = d;
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        #1 s_valid = 1'b0;
    endtask

    task automatic host_drive(input logic sk, input logic mo, input logic cs, input logic dc);
        host_sck = sk; host_mosi = mo; host_cs_n = cs; host_dc = dc;
        #1;
        chk(lcd_sck == sk && lcd_mosi == mo && lcd_cs_n == cs && lcd_dc == dc, "R8",
            "bypass routing", {lcd_sck, lcd_mosi, lcd_cs_n, lcd_dc}, {sk, mo, cs, dc});
    endtask

    // bypass in the middle of a pixel
    task automatic bypass_mid();
        int rx0;
        repeat (7) @(negedge clk);
        rx0 = rx_n;
        host_sck = 1'b0;
        bypass_en = 1'b1;
        host_drive(1'b1, 1'b0, 1'b0, 1'b0);
        host_drive(1'b0, 1'b1, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        chk(s_ready == 1'b0, "R9", "ready during mid bypass", s_ready, 0);
        host_drive(1'b1, 1'b1, 1'b0, 1'b0);
        chk(rx_n == rx0, "R9", "no words during bypass", rx_n, rx0);
        @(negedge clk);
        bypass_en = 1'b0;
        host_sck = 1'b0;
    endtask

    task automatic check_frame(input int kind, input int base, input int bd0, input int fd0, input int cs0, input string req);
        for (int i = 0; i < PX; i++)
            chk(rx_mem[(base + i) % 128] == px_val(kind, i), "R2", $sformatf("%s word %0d", req, i),
                rx_mem[(base + i) % 128], px_val(kind, i));
        chk(bd_n - bd0 == 3, "R6", $sformatf("%s band pulses", req), bd_n - bd0, 3);
        chk(bd_pos[bd0 % 32] == base + 6, "R5", $sformatf("%s band0 end", req), bd_pos[bd0 % 32], base + 6);
        chk(bd_pos[(bd0 + 1) % 32] == base + 12, "R5", $sformatf("%s band1 end", req), bd_pos[(bd0 + 1) % 32], base + 12);
        chk(bd_pos[(bd0 + 2) % 32] == base + 15, "R5", $sformatf("%s short band end", req), bd_pos[(bd0 + 2) % 32], base + 15);
        chk(fd_n - fd0 == 1 && fd_pos[fd0 % 32] == base + 15, "R6", $sformatf("%s frame pulse", req), fd_pos[fd0 % 32], base + 15);
        chk(csr_n - cs0 == 3 && csr_pos[cs0 % 32] == base + 6 && csr_pos[(cs0 + 1) % 32] == base + 12
            && csr_pos[(cs0 + 2) % 32] == base + 15, "R3", $sformatf("%s cs rises", req), csr_n - cs0, 3);
    endtask

    task automatic run_frame(input int kind, input int gap, input int byp_at, input string req);
        int base, bd0, fd0, cs0;
        base = rx_n; bd0 = bd_n; fd0 = fd_n; cs0 = csr_n;
        for (int i = 0; i < PX; i++) begin
            if (gap > 0) repeat (gap + (i % 3)) @(negedge clk);
            send_px(px_val(kind, i));
            if (i == byp_at) bypass_mid();
        end
        repeat (2 * DIV * 16 + 8) @(negedge clk);
        check_frame(kind, base, bd0, fd0, cs0, req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(lcd_cs_n == 1'b1, "R1", "cs after reset", lcd_cs_n, 1);
        chk(lcd_sck == 1'b0, "R1", "sck after reset", lcd_sck, 0);
        chk(lcd_dc == 1'b1, "R1", "dc after reset", lcd_dc, 1);
        chk(s_ready == 1'b1, "R1", "ready after reset", s_ready, 1);
        chk(band_done == 1'b0 && frame_done == 1'b0, "R1", "pulses after reset", {band_done, frame_done}, 0);
    endtask

    task automatic t_bypass_idle();
        int rx0;
        rx0 = rx_n;
        @(negedge clk);
        host_sck = 1'b0;
        bypass_en = 1'b1;
        host_drive(1'b0, 1'b1, 1'b0, 1'b0);
        host_drive(1'b1, 1'b0, 1'b1, 1'b1);
        host_drive(1'b0, 1'b0, 1'b0, 1'b1);
        s_valid = 1'b1;
        s_data  = 16'hDEAD;
        repeat (10) @(negedge clk);
        chk(s_ready == 1'b0, "R9", "ready during idle bypass", s_ready, 0);
        s_valid = 1'b0;
        host_drive(1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        bypass_en = 1'b0;
        host_sck = 1'b0;
        @(negedge clk);
        chk(lcd_cs_n == 1'b1 && s_ready == 1'b1, "R9", "still idle after bypass", {lcd_cs_n, s_ready}, 3);
        chk(rx_n == rx0, "R9", "no word from idle bypass", rx_n, rx0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_frame(1, 0, -1, "back-to-back");
        run_frame(2, 3, -1, "gapped");
        t_bypass_idle();
        run_frame(3, 1, 7, "mid-bypass");
        chk(sck_err == 0, "R4", "sck high/period errors", sck_err, 0);
        chk(rdy_err == 0, "R7", "ready high while sck high", rdy_err, 0);
        chk(dc_err == 0, "R3", "dc low while selected", dc_err, 0);
        chk(lcd_sck == 1'b0 && lcd_cs_n == 1'b1, "R4", "idle levels at end", {lcd_sck, lcd_cs_n}, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule